// File: doc/BRIEF.md
# One-Time-Programmable Memory Emulator

This block models a fuse-style read-only memory with registers. By default it holds 512 words of 8 bits, and the organisation can be changed with parameters. Every bit starts at a blank level. A bit can be burned once to the opposite level, and after that it stays there. Bits that are still blank can be burned at any later time.

A read is combinational. The addressed word appears on the data output whenever the chip-select inputs enable the part. The output flag then reports that the bus is driven. When the part is not enabled, the flag is low and the data output reads zero.

Programming is a synchronous, single-bit operation. A strobe carries one word address and one bit index. It takes effect only while chip select has the outputs turned off. A strobe that arrives while the outputs are enabled is dropped and flags an error for one cycle.

A plain reset keeps the burned contents. A reset taken with the factory-clear input high returns the whole array to blank.

Top module: `otp_rom_emu`

## Requirements
- R1: After a factory clear, every word reads as the blank level: all zeros when BLANK_HIGH=0, all ones when BLANK_HIGH=1.
- R2: A strobe on prog_stb_i while the outputs are disabled sets bit prog_bit_i of word prog_addr_i to the burned level. The burned level is 1 when BLANK_HIGH=0 and 0 when BLANK_HIGH=1. The new value can be read from the next clock cycle on.
- R3: A burned bit never returns to the blank level. Repeating the strobe for that bit leaves the word unchanged.
- R4: Each strobe changes exactly one bit. All other bits of the addressed word and of every other word are unchanged.
- R5: When CS_ACT_HIGH=0, the outputs are enabled only when every cs_i bit is 0. When CS_ACT_HIGH=1, they are enabled only when every cs_i bit is 1. While enabled, drive_o is 1 and data_o shows the addressed word.
- R6: If any cs_i bit is at the inactive level, drive_o is 0 and data_o is all zeros.
- R7: A strobe made while the outputs are enabled changes no bit. It drives prog_err_o high for exactly the following cycle. Otherwise prog_err_o is 0.
- R8: A reset with factory_clr_i low keeps every burned bit. A reset with factory_clr_i high returns all words to the blank level.
- R9: data_o follows addr_i within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for programming |
| rst_ni | input | 1 | Asynchronous reset, active low |
| factory_clr_i | input | 1 | When high during reset, the array returns to blank |
| addr_i | input | ADDR_W | Read address |
| cs_i | input | NUM_CS | Chip-select inputs |
| data_o | output | DATA_W | Read word, zero while not driven |
| drive_o | output | 1 | High while the outputs are enabled |
| prog_addr_i | input | ADDR_W | Word to program |
| prog_bit_i | input | BIT_W | Bit index within that word |
| prog_stb_i | input | 1 | Program strobe, one bit per strobe |
| prog_err_o | output | 1 | One-cycle pulse for a strobe made while enabled |

## Verification
Two instances are driven side by side: one with the default polarities, and a small one with the blank level high and active-high select. Each cs_i pattern therefore enables one instance, the other, or neither. Strobes under each pattern show whether a strobe programs or is rejected. Repeated strobes and strobes to neighbouring bits expose any undo path or a write that spills across bits. Address sweeps and two kinds of reset separate the combinational read path from the paths that keep and clear contents.

// File: rtl/otp_pkg.sv
package otp_pkg;
  // level a bit takes once burned, given the blank level
  function automatic logic burn_level(input logic blank_high);
    return ~blank_high;
  endfunction
endpackage

// File: rtl/otp_cs_decode.sv
module otp_cs_decode #(
  parameter int unsigned NUM_CS = 2,
  parameter bit          ACT_HIGH = 1'b0
) (
  input  logic [NUM_CS-1:0] cs_i,
  output logic              en_o
);
  if (ACT_HIGH) begin : g_high
    assign en_o = &cs_i;
  end else begin : g_low
    assign en_o = ~|cs_i;
  end
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BIT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              out_en_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_mask_o,
  output logic              err_o
);
  logic bit_ok;
  assign bit_ok = 32'(bit_i) < DATA_W;

  always_comb begin
    wr_mask_o = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (32'(bit_i) == i) wr_mask_o[i] = 1'b1;
    end
  end

  assign wr_en_o   = stb_i & ~out_en_i & bit_ok;
  assign wr_addr_o = addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= stb_i & out_en_i;
  end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned DATA_W     = 8,
  parameter bit          BLANK_HIGH = 1'b0,
  localparam int unsigned DEPTH     = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [DATA_W-1:0] BLANK_WORD = BLANK_HIGH ? '1 : '0;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] burned;

  // burning only ever moves bits away from blank
  if (otp_pkg::burn_level(BLANK_HIGH)) begin : g_burn_one
    assign burned = mem_q[wr_addr_i] | wr_mask_i;
  end else begin : g_burn_zero
    assign burned = mem_q[wr_addr_i] & ~wr_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if (clr_i) begin
        for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= BLANK_WORD;
      end
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= burned;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/otp_rom_emu.sv
module otp_rom_emu #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_CS      = 2,
  parameter bit          BLANK_HIGH  = 1'b0,
  parameter bit          CS_ACT_HIGH = 1'b0,
  localparam int unsigned BIT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              factory_clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_CS-1:0] cs_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [BIT_W-1:0]  prog_bit_i,
  input  logic              prog_stb_i,
  output logic              prog_err_o
);
  logic              out_en;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_mask;
  logic [DATA_W-1:0] rd_data;

  otp_cs_decode #(.NUM_CS(NUM_CS), .ACT_HIGH(CS_ACT_HIGH)) u_cs (
    .cs_i (cs_i),
    .en_o (out_en)
  );

  otp_prog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (prog_stb_i),
    .addr_i    (prog_addr_i),
    .bit_i     (prog_bit_i),
    .out_en_i  (out_en),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_mask_o (wr_mask),
    .err_o     (prog_err_o)
  );

  otp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLANK_HIGH(BLANK_HIGH)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (factory_clr_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_mask_i (wr_mask),
    .rd_addr_i (addr_i),
    .rd_data_o (rd_data)
  );

  assign drive_o = out_en;
  assign data_o  = out_en ? rd_data : '0;
endmodule

// File: rtl/otp_rom_emu_chk.sv
module otp_rom_emu_chk #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_CS      = 2,
  parameter bit          BLANK_HIGH  = 1'b0,
  parameter bit          CS_ACT_HIGH = 1'b0,
  parameter int unsigned BIT_W       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NUM_CS-1:0] cs_i,
  input logic [DATA_W-1:0] data_o,
  input logic              drive_o,
  input logic [ADDR_W-1:0] prog_addr_i,
  input logic [BIT_W-1:0]  prog_bit_i,
  input logic              prog_stb_i,
  input logic              prog_err_o
);
  localparam logic BURN = ~BLANK_HIGH;
  logic sel_ok;
  assign sel_ok = CS_ACT_HIGH ? (cs_i == '1) : (cs_i == '0);

  a_r5_drive_matches_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o == sel_ok);

  a_r6_off_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> data_o == '0);

  a_r7_err_after_enabled_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_stb_i && drive_o) |=> prog_err_o);

  a_r7_err_only_when_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_stb_i && drive_o) |=> !prog_err_o);

  a_r2_burn_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_stb_i && !drive_o && 32'(prog_bit_i) < DATA_W) |=>
      (!drive_o || addr_i != $past(prog_addr_i) || data_o[$past(prog_bit_i)] == BURN));

  // R7: enabled cycles with a fixed address give a fixed word
  a_r7_enabled_word_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && drive_o && $past(drive_o) && $stable(addr_i)) |-> $stable(data_o));
endmodule

bind otp_rom_emu otp_rom_emu_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS),
  .BLANK_HIGH(BLANK_HIGH), .CS_ACT_HIGH(CS_ACT_HIGH), .BIT_W(BIT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .cs_i(cs_i),
  .data_o(data_o), .drive_o(drive_o), .prog_addr_i(prog_addr_i),
  .prog_bit_i(prog_bit_i), .prog_stb_i(prog_stb_i), .prog_err_o(prog_err_o)
);

// File: tb/otp_rom_emu_tb_top.sv
module otp_rom_emu_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fclr = 1'b1;
  logic [8:0] addr = '0;
  logic [1:0] cs = 2'b01;
  logic [8:0] paddr = '0;
  logic [2:0] pbit = '0;
  logic       pstb = 1'b0;

  logic [7:0] d0;
  logic       drv0, err0;
  logic [3:0] d1;
  logic       drv1, err1;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string req = "R1";

  bit [7:0] m0 [512];
  bit [3:0] m1 [16];
  bit       e0 = 0, e1 = 0;

  always #4 clk_i = ~clk_i;

  otp_rom_emu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .factory_clr_i(fclr), .addr_i(addr), .cs_i(cs),
    .data_o(d0), .drive_o(drv0), .prog_addr_i(paddr), .prog_bit_i(pbit),
    .prog_stb_i(pstb), .prog_err_o(err0)
  );

  otp_rom_emu #(.ADDR_W(4), .DATA_W(4), .BLANK_HIGH(1'b1), .CS_ACT_HIGH(1'b1)) dut_alt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .factory_clr_i(fclr), .addr_i(addr[3:0]), .cs_i(cs),
    .data_o(d1), .drive_o(drv1), .prog_addr_i(paddr[3:0]), .prog_bit_i(pbit[1:0]),
    .prog_stb_i(pstb), .prog_err_o(err1)
  );

  // reference model: compare, then apply the inputs the next edge will take
  always @(negedge clk_i) begin
    bit en0, en1;
    bit [7:0] x0;
    bit [3:0] x1;
    en0 = (cs == 2'b00);
    en1 = (cs == 2'b11);
    x0 = en0 ? m0[addr] : 8'h00;
    x1 = en1 ? m1[addr[3:0]] : 4'h0;
    n_cmp++;
    if (d0 !== x0 || drv0 !== en0 || err0 !== (rst_ni ? e0 : 1'b0)) begin
      n_bad++;
      $display("FAIL %s default: data=%h drive=%b err=%b expected data=%h drive=%b err=%b",
               req, d0, drv0, err0, x0, en0, rst_ni ? e0 : 1'b0);
    end
    n_cmp++;
    if (d1 !== x1 || drv1 !== en1 || err1 !== (rst_ni ? e1 : 1'b0)) begin
      n_bad++;
      $display("FAIL %s alt: data=%h drive=%b err=%b expected data=%h drive=%b err=%b",
               req, d1, drv1, err1, x1, en1, rst_ni ? e1 : 1'b0);
    end
    if (!rst_ni) begin
      e0 = 0; e1 = 0;
      if (fclr) begin
        foreach (m0[i]) m0[i] = 8'h00;
        foreach (m1[i]) m1[i] = 4'hF;
      end
    end else begin
      e0 = pstb && en0;
      e1 = pstb && en1;
      if (pstb && !en0) m0[paddr] = m0[paddr] | (8'h01 << pbit);
      if (pstb && !en1) m1[paddr[3:0]] = m1[paddr[3:0]] & ~(4'h1 << pbit[1:0]);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic burn(input logic [8:0] a, input logic [2:0] b);
    paddr = a; pbit = b; pstb = 1'b1;
    tick(1);
    pstb = 1'b0;
  endtask

  task automatic sweep(input logic [1:0] c, input int lo, input int hi);
    cs = c;
    for (int a = lo; a <= hi; a++) begin
      addr = 9'(a);
      tick(1);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    // R8: factory clear under reset
    tick(3);
    rst_ni = 1'b1; fclr = 1'b0;
    tick(1);
    // R1: blank contents, default all 0, alt all 1
    req = "R1"; sweep(2'b00, 0, 20); sweep(2'b11, 0, 15);
    // R6: one select inactive disables both
    req = "R6"; sweep(2'b01, 0, 4); sweep(2'b10, 500, 511);
    // R2 and R4: single-bit burns with outputs off
    req = "R2"; cs = 2'b01;
    burn(9'd5, 3'd3); burn(9'd5, 3'd0); burn(9'd511, 3'd7); burn(9'd0, 3'd0);
    burn(9'd6, 3'd1); burn(9'd21, 3'd2);
    req = "R4"; sweep(2'b00, 0, 22); sweep(2'b00, 505, 511); sweep(2'b11, 0, 15);
    // R3: repeated burns leave words unchanged
    req = "R3"; cs = 2'b10;
    burn(9'd5, 3'd3); burn(9'd5, 3'd3); burn(9'd0, 3'd0);
    sweep(2'b00, 0, 6); sweep(2'b11, 0, 6);
    // R7: strobes while enabled are rejected and pulse the error
    req = "R7"; cs = 2'b00; addr = 9'd9;
    burn(9'd9, 3'd4); tick(1); burn(9'd9, 3'd5); burn(9'd9, 3'd6);
    cs = 2'b11; addr = 9'd9;
    burn(9'd9, 3'd1); tick(1); burn(9'd10, 3'd3);
    sweep(2'b00, 8, 11); sweep(2'b11, 8, 11);
    // R9: address changes every cycle, read without an edge
    req = "R9"; cs = 2'b00;
    for (int k = 0; k < 40; k++) begin
      addr = 9'((k * 37) % 512);
      #1;
      n_cmp++;
      if (d0 !== m0[addr]) begin
        n_bad++;
        $display("FAIL R9: data=%h expected=%h", d0, m0[addr]);
      end
      tick(1);
    end
    // R8: plain reset keeps contents
    req = "R8"; cs = 2'b01; rst_ni = 1'b0; tick(2); rst_ni = 1'b1; tick(1);
    sweep(2'b00, 0, 22); sweep(2'b11, 0, 15);
    // R8: factory clear returns to blank
    cs = 2'b01; fclr = 1'b1; rst_ni = 1'b0; tick(2); rst_ni = 1'b1; fclr = 1'b0; tick(1);
    sweep(2'b00, 0, 22); sweep(2'b00, 511, 511); sweep(2'b11, 0, 15);
    // R3: blank bits remain programmable later
    req = "R3"; cs = 2'b01; burn(9'd5, 3'd6); sweep(2'b00, 5, 5); sweep(2'b11, 5, 5);
    done = 1;
    summary();
  end
endmodule